// File: doc/BRIEF.md
# Write-Back Set-Associative Cache Tag Controller

This block keeps only the tag state of a write-back, write-allocate set-associative cache; it holds no data. Each request brings an address, a byte count and a load/store flag through a valid/ready handshake. The controller looks the address up, answers with a one-cycle response pulse that says hit or miss, and keeps running statistics for both directions.

On a miss the replacement way comes from a 16-bit pseudo-random generator. If that way holds a valid, modified line, the controller first issues a line write-back on the downstream port. It then issues a line fill and installs the new tag. Downstream requests are held until acknowledged, and only one request is in flight at a time.

The controller is a four-state machine. ST_IDLE accepts a request (transition *accept*, to ST_LOOKUP). ST_LOOKUP either answers a hit (*hit*, back to ST_IDLE), or on a miss advances the generator and goes to ST_WRBACK (*evict dirty*) or ST_FILL (*evict clean*). ST_WRBACK waits for the acknowledge (*wb done*, to ST_FILL). ST_FILL waits for the acknowledge, installs the tag and answers the miss (*fill done*, to ST_IDLE).

Top module: `cache_tag_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves every line invalid and clean, every counter at zero, `req_ready` high and `mem_valid`/`resp_valid` low.
- R2: With OFF_W = log2(LINE_BYTES), the set is `addr[OFF_W +: log2(SETS)]` and the stored tag is `addr >> OFF_W`, index bits included.
- R3: A lookup hits when a valid way in the set holds the same tag, whatever its dirty flag. `resp_valid` pulses with `resp_hit=1` in the cycle after acceptance, and a load hit changes no tag state.
- R4: A store hit marks that way dirty, so its later eviction produces a write-back.
- R5: The generator is a right-shifting Galois LFSR with seed 16'hACE1. Each step computes s = (s>>1) ^ (s[0] ? 16'hB400 : 0), and it steps once per miss. The victim way is the new value modulo WAYS.
- R6: A victim that is valid and dirty first causes a downstream request with `mem_write=1` at address `victim_tag << OFF_W`. The request holds `mem_valid`, address and type steady until `mem_ack`.
- R7: The fill request (`mem_write=0`) goes out next at the miss address with its low OFF_W bits cleared. `resp_valid` with `resp_hit=0` pulses in the cycle the fill is acknowledged.
- R8: After a miss the victim holds the new tag, valid, and dirty only for a store, so a line loaded on a load miss evicts with no write-back.
- R9: `cnt_rd_acc`/`cnt_wr_acc` count loads/stores accepted, and `cnt_rd_miss`/`cnt_wr_miss` count those that missed.
- R10: `cnt_rd_bytes`/`cnt_wr_bytes` add each request's `req_bytes` by direction, hit or miss.
- R11: `cnt_wb` rises by one on each acknowledged write-back.
- R12: `req_ready` is low from the cycle after acceptance until the request has been answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Byte address |
| req_bytes | input | BYTES_W | Bytes touched by the access |
| req_store | input | 1 | 1 for a store, 0 for a load |
| resp_valid | output | 1 | One-cycle answer pulse |
| resp_hit | output | 1 | 1 on hit, 0 on miss |
| mem_valid | output | 1 | Downstream line request present |
| mem_write | output | 1 | 1 write-back, 0 fill |
| mem_addr | output | ADDR_W | Line-aligned downstream address |
| mem_ack | input | 1 | Downstream accepts the request |
| cnt_rd_acc | output | CNT_W | Loads accepted |
| cnt_wr_acc | output | CNT_W | Stores accepted |
| cnt_rd_miss | output | CNT_W | Load misses |
| cnt_wr_miss | output | CNT_W | Store misses |
| cnt_rd_bytes | output | CNT_W | Bytes loaded |
| cnt_wr_bytes | output | CNT_W | Bytes stored |
| cnt_wb | output | CNT_W | Write-backs done |

## Verification
The bench sends a long run of loads and stores that pile onto one set, so victims come out of the generator both clean and dirty. A controller that compared the dirty flag would then miss on lines it had just stored to. One that stepped the generator on hits, or took the victim from the old value, would write back or fill the wrong lines. Write-backs of lines near the top of the address space catch a stored tag that drops the index bits, because those produce wrong write-back addresses. The acknowledge latency varies from zero to two cycles. A controller that dropped a request before `mem_ack`, answered before the fill, or counted a write-back twice shows up as a mismatch in the expected downstream order or in the counters.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_WRBACK = 2'd2,
        ST_FILL   = 2'd3
    } ctl_state_t;

    localparam int          RNG_W    = 16;
    localparam logic [15:0] RNG_TAPS = 16'hB400;

endpackage

// File: rtl/victim_lfsr.sv
module victim_lfsr
    import cache_tag_pkg::*;
#(
    parameter logic [RNG_W-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [RNG_W-1:0] rng_next
);

    logic [RNG_W-1:0] rng_q;

    always_comb begin
        rng_next = {1'b0, rng_q[RNG_W-1:1]};
        if (rng_q[0]) begin
            rng_next = rng_next ^ RNG_TAPS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rng_q <= SEED;
        end else if (step) begin
            rng_q <= rng_next;
        end
    end

endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int TAG_W = 28,
    parameter int IDX_W = 2,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    input  logic [WAY_W-1:0] vic_way,
    output logic             vic_valid,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag,
    input  logic             mark_dirty,
    input  logic             fill_en,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_dirty
);

    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic             valid_q [SETS][WAYS];
    logic             dirty_q [SETS][WAYS];
    logic [WAYS-1:0]  match;

    for (genvar w = 0; w < WAYS; w++) begin : g_match
        assign match[w] = valid_q[set_idx][w] && (tag_q[set_idx][w] == look_tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end

    assign vic_valid = valid_q[set_idx][vic_way];
    assign vic_dirty = dirty_q[set_idx][vic_way];
    assign vic_tag   = tag_q[set_idx][vic_way];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                    dirty_q[s][w] <= 1'b0;
                    tag_q[s][w]   <= '0;
                end
            end
        end else begin
            if (mark_dirty) begin
                dirty_q[set_idx][hit_way] <= 1'b1;
            end
            if (fill_en) begin
                valid_q[set_idx][fill_way] <= 1'b1;
                dirty_q[set_idx][fill_way] <= fill_dirty;
                tag_q[set_idx][fill_way]   <= fill_tag;
            end
        end
    end

endmodule

// File: rtl/cache_stat_counters.sv
module cache_stat_counters #(
    parameter int BYTES_W = 8,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_en,
    input  logic               acc_store,
    input  logic               acc_miss,
    input  logic [BYTES_W-1:0] acc_bytes,
    input  logic               wb_en,
    output logic [CNT_W-1:0]   rd_acc,
    output logic [CNT_W-1:0]   wr_acc,
    output logic [CNT_W-1:0]   rd_miss,
    output logic [CNT_W-1:0]   wr_miss,
    output logic [CNT_W-1:0]   rd_bytes,
    output logic [CNT_W-1:0]   wr_bytes,
    output logic [CNT_W-1:0]   wb_cnt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_acc   <= '0;
            wr_acc   <= '0;
            rd_miss  <= '0;
            wr_miss  <= '0;
            rd_bytes <= '0;
            wr_bytes <= '0;
            wb_cnt   <= '0;
        end else begin
            if (acc_en && acc_store) begin
                wr_acc   <= wr_acc + ONE;
                wr_bytes <= wr_bytes + CNT_W'(acc_bytes);
                if (acc_miss) begin
                    wr_miss <= wr_miss + ONE;
                end
            end
            if (acc_en && !acc_store) begin
                rd_acc   <= rd_acc + ONE;
                rd_bytes <= rd_bytes + CNT_W'(acc_bytes);
                if (acc_miss) begin
                    rd_miss <= rd_miss + ONE;
                end
            end
            if (wb_en) begin
                wb_cnt <= wb_cnt + ONE;
            end
        end
    end

endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
    import cache_tag_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          BYTES_W    = 8,
    parameter int          CNT_W      = 32,
    parameter int          SETS       = 4,
    parameter int          WAYS       = 2,
    parameter int          LINE_BYTES = 16,
    parameter logic [15:0] RNG_SEED   = 16'hACE1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [BYTES_W-1:0] req_bytes,
    input  logic               req_store,
    output logic               resp_valid,
    output logic               resp_hit,
    output logic               mem_valid,
    output logic               mem_write,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_ack,
    output logic [CNT_W-1:0]   cnt_rd_acc,
    output logic [CNT_W-1:0]   cnt_wr_acc,
    output logic [CNT_W-1:0]   cnt_rd_miss,
    output logic [CNT_W-1:0]   cnt_wr_miss,
    output logic [CNT_W-1:0]   cnt_rd_bytes,
    output logic [CNT_W-1:0]   cnt_wr_bytes,
    output logic [CNT_W-1:0]   cnt_wb
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int TAG_W = ADDR_W - OFF_W;

    initial begin
        if (SETS < 2 || (SETS & (SETS - 1)) != 0) $error("SETS must be a power of two, at least 2");
        if (LINE_BYTES < 8 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) $error("LINE_BYTES must be a power of two, at least 8");
    end

    ctl_state_t         state_q, state_d;
    logic [TAG_W-1:0]   line_q;
    logic [BYTES_W-1:0] bytes_q;
    logic               store_q;
    logic [WAY_W-1:0]   vic_way_q;
    logic [TAG_W-1:0]   vic_tag_q;

    logic               lk_hit;
    logic [WAY_W-1:0]   lk_hit_way;
    logic               lk_vic_valid;
    logic               lk_vic_dirty;
    logic [TAG_W-1:0]   lk_vic_tag;
    logic [RNG_W-1:0]   rng_next;
    logic [WAY_W-1:0]   rng_way;
    logic [WAY_W-1:0]   sel_way;

    logic               accept;
    logic               miss_now;
    logic               mark_dirty;
    logic               fill_en;
    logic               wb_en;
    logic               acc_en;

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign miss_now = (state_q == ST_LOOKUP) && !lk_hit;
    assign rng_way  = WAY_W'(rng_next % RNG_W'(WAYS));
    assign sel_way  = miss_now ? rng_way : vic_way_q;

    victim_lfsr #(
        .SEED     (RNG_SEED)
    ) u_rng (
        .clk      (clk),
        .rst      (rst),
        .step     (miss_now),
        .rng_next (rng_next)
    );

    cache_tag_store #(
        .SETS       (SETS),
        .WAYS       (WAYS),
        .TAG_W      (TAG_W),
        .IDX_W      (IDX_W),
        .WAY_W      (WAY_W)
    ) u_tags (
        .clk        (clk),
        .rst        (rst),
        .set_idx    (line_q[IDX_W-1:0]),
        .look_tag   (line_q),
        .hit        (lk_hit),
        .hit_way    (lk_hit_way),
        .vic_way    (sel_way),
        .vic_valid  (lk_vic_valid),
        .vic_dirty  (lk_vic_dirty),
        .vic_tag    (lk_vic_tag),
        .mark_dirty (mark_dirty),
        .fill_en    (fill_en),
        .fill_way   (vic_way_q),
        .fill_tag   (line_q),
        .fill_dirty (store_q)
    );

    cache_stat_counters #(
        .BYTES_W   (BYTES_W),
        .CNT_W     (CNT_W)
    ) u_stats (
        .clk       (clk),
        .rst       (rst),
        .acc_en    (acc_en),
        .acc_store (store_q),
        .acc_miss  (!lk_hit),
        .acc_bytes (bytes_q),
        .wb_en     (wb_en),
        .rd_acc    (cnt_rd_acc),
        .wr_acc    (cnt_wr_acc),
        .rd_miss   (cnt_rd_miss),
        .wr_miss   (cnt_wr_miss),
        .rd_bytes  (cnt_rd_bytes),
        .wr_bytes  (cnt_wr_bytes),
        .wb_cnt    (cnt_wb)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (lk_hit) begin
                    state_d = ST_IDLE;
                end else if (lk_vic_valid && lk_vic_dirty) begin
                    state_d = ST_WRBACK;
                end else begin
                    state_d = ST_FILL;
                end
            end
            ST_WRBACK: begin
                if (mem_ack) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (mem_ack) state_d = ST_IDLE;
            end
        endcase
    end

    // State and request registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            line_q    <= '0;
            bytes_q   <= '0;
            store_q   <= 1'b0;
            vic_way_q <= '0;
            vic_tag_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                line_q  <= req_addr[ADDR_W-1:OFF_W];
                bytes_q <= req_bytes;
                store_q <= req_store;
            end
            if (miss_now) begin
                vic_way_q <= rng_way;
                vic_tag_q <= lk_vic_tag;
            end
        end
    end

    // Outputs and strobes decoded from the state
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        resp_hit   = 1'b0;
        mem_valid  = 1'b0;
        mem_write  = 1'b0;
        mem_addr   = {line_q, {OFF_W{1'b0}}};
        mark_dirty = 1'b0;
        fill_en    = 1'b0;
        wb_en      = 1'b0;
        acc_en     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_LOOKUP: begin
                acc_en = 1'b1;
                if (lk_hit) begin
                    resp_valid = 1'b1;
                    resp_hit   = 1'b1;
                    mark_dirty = store_q;
                end
            end
            ST_WRBACK: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {vic_tag_q, {OFF_W{1'b0}}};
                wb_en     = mem_ack;
            end
            ST_FILL: begin
                mem_valid  = 1'b1;
                fill_en    = mem_ack;
                resp_valid = mem_ack;
            end
        endcase
    end

endmodule

// File: rtl/cache_tag_ctrl_chk.sv
module cache_tag_ctrl_chk #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 32,
    parameter int LINE_BYTES = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              mem_valid,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [CNT_W-1:0]  cnt_wb
);

    localparam int OFF_W = $clog2(LINE_BYTES);

    assert_mem_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

    assert_fill_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[OFF_W-1:0] == '0));

    assert_fill_after_wb_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write && mem_ack) |=> (mem_valid && !mem_write));

    assert_wb_count_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write && mem_ack) |=> (cnt_wb == $past(cnt_wb) + CNT_W'(1)));

    assert_busy_after_accept_R12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_no_ready_while_busy_R12: assert property (@(posedge clk) disable iff (rst)
        (resp_valid || mem_valid) |-> !req_ready);

endmodule

bind cache_tag_ctrl cache_tag_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .LINE_BYTES (LINE_BYTES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .mem_valid  (mem_valid),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .cnt_wb     (cnt_wb)
);

// File: tb/cache_tag_ctrl_tb.sv
`timescale 1ns/1ps
module cache_tag_ctrl_tb;

    localparam int SETS  = 4;
    localparam int WAYS  = 2;
    localparam int OFF_W = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_bytes = '0;
    logic        req_store = 1'b0;
    logic        resp_valid, resp_hit;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] c_ra, c_wa, c_rm, c_wm, c_rb, c_wb, c_bk;

    always #2.5 clk = ~clk;

    cache_tag_ctrl u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_bytes(req_bytes), .req_store(req_store),
        .resp_valid(resp_valid), .resp_hit(resp_hit),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .cnt_rd_acc(c_ra), .cnt_wr_acc(c_wa), .cnt_rd_miss(c_rm), .cnt_wr_miss(c_wm),
        .cnt_rd_bytes(c_rb), .cnt_wr_bytes(c_wb), .cnt_wb(c_bk)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int ack_lat = 0;

    // reference model state
    bit          m_val [SETS][WAYS];
    bit          m_dty [SETS][WAYS];
    logic [27:0] m_tag [SETS][WAYS];
    logic [15:0] m_rng = 16'hACE1;
    int e_ra = 0, e_wa = 0, e_rm = 0, e_wm = 0, e_rb = 0, e_wb = 0, e_bk = 0;

    // scoreboard queues
    bit          q_hit [$];
    bit          q_mwr [$];
    logic [31:0] q_mad [$];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic check_counters();
        check(c_ra == 32'(e_ra), "R9 read accesses", c_ra, e_ra);
        check(c_wa == 32'(e_wa), "R9 write accesses", c_wa, e_wa);
        check(c_rm == 32'(e_rm), "R9 read misses", c_rm, e_rm);
        check(c_wm == 32'(e_wm), "R9 write misses", c_wm, e_wm);
        check(c_rb == 32'(e_rb), "R10 bytes read", c_rb, e_rb);
        check(c_wb == 32'(e_wb), "R10 bytes written", c_wb, e_wb);
        check(c_bk == 32'(e_bk), "R11 writebacks", c_bk, e_bk);
    endtask

    // driver: predicts outcome, pushes expectations, then issues the request
    task automatic do_req(input logic [31:0] addr, input logic [7:0] nb, input bit st);
        logic [27:0] tg;
        int idx;
        int way;
        bit hit;
        tg  = addr[31:OFF_W];                  // R2: whole shifted address
        idx = int'(addr[OFF_W +: 2]);          // R2: set index bits
        hit = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!hit && m_val[idx][w] && m_tag[idx][w] == tg) begin
                hit = 1'b1;
                if (st) m_dty[idx][w] = 1'b1;  // R4
            end
        end
        if (st) begin e_wa++; e_wb += int'(nb); end else begin e_ra++; e_rb += int'(nb); end
        if (!hit) begin
            if (st) e_wm++; else e_rm++;
            m_rng = {1'b0, m_rng[15:1]} ^ (m_rng[0] ? 16'hB400 : 16'h0000);   // R5
            way   = int'(m_rng % 16'(WAYS));
            if (m_val[idx][way] && m_dty[idx][way]) begin
                q_mwr.push_back(1'b1);
                q_mad.push_back({m_tag[idx][way], 4'h0});
                e_bk++;
            end
            q_mwr.push_back(1'b0);
            q_mad.push_back({addr[31:OFF_W], 4'h0});
            m_val[idx][way] = 1'b1;            // R8
            m_dty[idx][way] = st;
            m_tag[idx][way] = tg;
        end
        q_hit.push_back(hit);

        @(negedge clk);
        req_addr  = addr;
        req_bytes = nb;
        req_store = st;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = 32'hDEAD_BEEF;
        check(req_ready == 1'b0, "R12 busy after accept", req_ready, 0);
        while (!req_ready) @(negedge clk);
        check(q_hit.size() == 0 && q_mad.size() == 0, "R7 all expected items seen",
              q_hit.size() + q_mad.size(), 0);
        check_counters();
    endtask

    // monitor: response pulses
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && resp_valid) begin
                if (q_hit.size() == 0) begin
                    check(1'b0, "R3 unexpected response", 1, 0);
                end else begin
                    bit e;
                    e = q_hit.pop_front();
                    check(resp_hit == e, "R3 hit flag", resp_hit, e);
                end
            end
        end
    end

    // downstream responder and monitor
    initial begin
        bit seen = 1'b0;
        int wait_cnt = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (!rst && mem_valid) begin
                if (!seen) begin
                    seen = 1'b1;
                    wait_cnt = ack_lat;
                    if (q_mad.size() == 0) begin
                        check(1'b0, "R6 unexpected downstream request", mem_addr, 0);
                    end else begin
                        bit ew;
                        logic [31:0] ea;
                        ew = q_mwr.pop_front();
                        ea = q_mad.pop_front();
                        check(mem_write == ew, ew ? "R6 writeback type" : "R7 fill type", mem_write, ew);
                        check(mem_addr == ea, ew ? "R6 writeback address" : "R7 fill address", mem_addr, ea);
                    end
                end
                if (wait_cnt == 0) begin
                    mem_ack = 1'b1;
                    seen = 1'b0;
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_val[s][w] = 1'b0; m_dty[s][w] = 1'b0; m_tag[s][w] = '0;
            end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(mem_valid == 1'b0 && resp_valid == 1'b0, "R1 idle outputs", {mem_valid, resp_valid}, 0);
        check_counters();

        do_req(32'h0000_0100, 8'd4, 1'b0);   // load miss, clean fill
        do_req(32'h0000_0104, 8'd4, 1'b0);   // R3 load hit
        do_req(32'h0000_0108, 8'd8, 1'b1);   // R4 store hit marks dirty
        do_req(32'h0000_0110, 8'd2, 1'b1);   // R2 other set, store miss
        do_req(32'h0000_010C, 8'd1, 1'b0);   // R3 hit on dirty line
        do_req(32'hFFFF_FFC0, 8'd16, 1'b1);  // R2 high tag bits, set 0

        // R5 R6 R8: many lines on one set, mixed loads and stores and ack latencies
        for (int i = 0; i < 40; i++) begin
            ack_lat = i % 3;
            do_req(32'h0000_1000 + 32'((i % 5) * 64) + 32'((i % 3) * 4),
                   8'(1 << (i % 4)), (i % 2) == 1);
        end
        ack_lat = 1;
        for (int i = 0; i < 16; i++) begin
            do_req(32'hFFFF_FF00 + 32'((i % 8) * 16), 8'd8, (i % 3) == 0);
        end

        repeat (4) @(negedge clk);
        check(req_ready == 1'b1 && mem_valid == 1'b0, "R12 idle at end", {req_ready, mem_valid}, 2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule